// File: doc/BRIEF.md
# Hebbian Permanence Update Engine

This block performs the learning step of a spatial pooler once the winning columns for an input vector are known. Each column owns a fixed set of potential synapses. Every synapse samples one bit of the input vector and keeps a permanence value in an external memory. For each winning column the engine walks through that column's synapses in turn. A synapse whose input bit is set gains one step of permanence, and a synapse whose input bit is clear loses one step. The result is clamped to the range from zero to the full-scale value.

Each synapse also has a binary connected state, held in registers and exported as a flat vector. That state changes only when a written permanence lands exactly on an endpoint. It becomes connected at full scale and disconnected at zero. At every value in between it keeps its previous state, which gives the weight hysteresis across the whole permanence range.

A single-cycle start pulse captures the winner vector and the input vector. The engine then holds busy while it reads, updates and writes back the synapses of each winning column, taking the columns in ascending index order. When busy falls, every write of the pass is already in the memory.

Top module: `hebb_perm_engine`

## Requirements
- R1: After synchronous reset the engine is idle: busy, read enable and write enable are low and every connected bit is 0.
- R2: A start pulse is accepted only while busy is low. Busy is high in the cycle after an accepted start. A start pulse raised while busy is high has no effect on the pass in progress or on any later write.
- R3: Only synapses of columns whose winner bit is 1 are read and written. Write addresses within one pass are strictly increasing, so columns are handled in ascending index order.
- R4: Synapse s of column c uses input bit (c*COL_SKEW + s*SYN_STRIDE) mod NUM_INPUTS of the captured input vector.
- R5: When the synapse's input bit is 1, the written permanence is the old value plus PERM_STEP, saturating at PERM_MAX.
- R6: When the synapse's input bit is 0, the written permanence is the old value minus PERM_STEP, saturating at 0 with no wrap.
- R7: A stored permanence above PERM_MAX is treated as PERM_MAX before the step is applied.
- R8: A synapse's connected bit becomes 1 when PERM_MAX is written to it and becomes 0 when 0 is written to it. Any other written value leaves the bit unchanged.
- R9: Synapse s of column c lives at memory address c*SYN_PER_COL + s. Each synapse of every winning column is written exactly once per pass. Reads have one cycle of latency.
- R10: Writes occur only while busy is high. Busy falls only after the last write of the pass, including a pass with no winners, which writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse that captures the winners and inputs |
| winners_i | input | NUM_COLS | One bit per column, 1 for a winning column |
| inputs_i | input | NUM_INPUTS | Input bit vector |
| busy_o | output | 1 | High while a pass is in progress |
| mem_rd_en_o | output | 1 | Permanence memory read enable |
| mem_raddr_o | output | ADDR_W | Read address |
| mem_rdata_i | input | PERM_W | Read data, valid the cycle after the read |
| mem_we_o | output | 1 | Permanence memory write enable |
| mem_waddr_o | output | ADDR_W | Write address |
| mem_wdata_o | output | PERM_W | Write data |
| conn_o | output | NUM_COLS*SYN_PER_COL | Connected bit per synapse, index c*SYN_PER_COL+s |

## Verification
The bench builds the engine with eight columns of six synapses, forty inputs, a full scale of 10 and a step of 3. Because the step does not divide the full scale, both clamps are reached from values that are not aligned to the step, for example 9 rising to 10 and 2 falling to 0. A four-bit permanence word can hold 12 or 15, which makes the out-of-range clamp of R7 reachable. A short ladder of passes drives one synapse down from full scale to zero and back up, so the hysteresis of the connected bit is observed at both ends.

// File: rtl/hpe_pkg.sv
package hpe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_RUN   = 2'd2,
    ST_FLUSH = 2'd3
  } hpe_state_e;

  // Input bit sampled by synapse syn of column col.
  function automatic int unsigned syn_src(input int unsigned col,
                                          input int unsigned syn,
                                          input int unsigned skew,
                                          input int unsigned stride,
                                          input int unsigned n_in);
    return (col * skew + syn * stride) % n_in;
  endfunction

endpackage

// File: rtl/hpe_winner_pick.sv
module hpe_winner_pick #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     pending_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  // Lowest pending index wins.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pending_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/hpe_perm_step.sv
module hpe_perm_step #(
  parameter int unsigned PERM_MAX  = 100,
  parameter int unsigned PERM_STEP = 1,
  parameter int unsigned W         = 7
) (
  input  logic [W-1:0] perm_i,
  input  logic         active_i,
  output logic [W-1:0] perm_o,
  output logic         hit_max_o,
  output logic         hit_min_o
);

  localparam logic [W:0] MAXV  = (W+1)'(PERM_MAX);
  localparam logic [W:0] STEPV = (W+1)'(PERM_STEP);

  logic [W:0] base;
  logic [W:0] raised;

  always_comb begin
    base   = ({1'b0, perm_i} > MAXV) ? MAXV : {1'b0, perm_i};
    raised = base + STEPV;
    if (active_i) begin
      perm_o = (raised > MAXV) ? MAXV[W-1:0] : raised[W-1:0];
    end else begin
      perm_o = (base >= STEPV) ? W'(base - STEPV) : '0;
    end
  end

  assign hit_max_o = (perm_o == MAXV[W-1:0]);
  assign hit_min_o = (perm_o == '0);

endmodule

// File: rtl/hpe_conn_bank.sv
module hpe_conn_bank #(
  parameter int unsigned N  = 400,
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_i,
  input  logic [AW-1:0] addr_i,
  input  logic          set_i,
  input  logic          clr_i,
  output logic [N-1:0]  conn_o
);

  logic [N-1:0] conn_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        conn_q[g] <= 1'b0;
      end else if (upd_i && (addr_i == AW'(g))) begin
        if (set_i) begin
          conn_q[g] <= 1'b1;
        end else if (clr_i) begin
          conn_q[g] <= 1'b0;
        end
      end
    end
  end

  assign conn_o = conn_q;

  // R8: at most one synapse changes its connected state per cycle
  conn_single_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(conn_q ^ $past(conn_q)) <= 1)
    else $error("more than one connected bit changed in a cycle");

endmodule

// File: rtl/hebb_perm_engine.sv
module hebb_perm_engine #(
  parameter int unsigned NUM_COLS    = 16,
  parameter int unsigned SYN_PER_COL = 25,
  parameter int unsigned NUM_INPUTS  = 400,
  parameter int unsigned PERM_MAX    = 100,
  parameter int unsigned PERM_STEP   = 1,
  parameter int unsigned COL_SKEW    = 7,
  parameter int unsigned SYN_STRIDE  = 16,
  localparam int unsigned NUM_SYN    = NUM_COLS * SYN_PER_COL,
  localparam int unsigned PERM_W     = $clog2(PERM_MAX + 1),
  localparam int unsigned ADDR_W     = (NUM_SYN > 1) ? $clog2(NUM_SYN) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [NUM_COLS-1:0]   winners_i,
  input  logic [NUM_INPUTS-1:0] inputs_i,
  output logic                  busy_o,
  output logic                  mem_rd_en_o,
  output logic [ADDR_W-1:0]     mem_raddr_o,
  input  logic [PERM_W-1:0]     mem_rdata_i,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_waddr_o,
  output logic [PERM_W-1:0]     mem_wdata_o,
  output logic [NUM_SYN-1:0]    conn_o
);

  import hpe_pkg::*;

  localparam int unsigned COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
  localparam int unsigned SYN_W = (SYN_PER_COL > 1) ? $clog2(SYN_PER_COL) : 1;
  localparam logic [SYN_W-1:0] SYN_LAST = SYN_W'(SYN_PER_COL - 1);

  hpe_state_e state_q;
  logic [NUM_COLS-1:0]   win_q;
  logic [NUM_COLS-1:0]   pend_q;
  logic [NUM_INPUTS-1:0] inp_q;
  logic [COL_W-1:0]      col_q;
  logic [SYN_W-1:0]      syn_q;
  logic [ADDR_W-1:0]     addr_q;

  // stage 1: read issued
  logic              rd_en_q;
  logic [ADDR_W-1:0] raddr_q;
  logic [COL_W-1:0]  rcol_q;
  logic              rinbit_q;
  // stage 2: read data present
  logic              d_vld_q;
  logic [ADDR_W-1:0] d_addr_q;
  logic              d_inbit_q;
  // stage 3: write issued
  logic              we_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [PERM_W-1:0] wdata_q;

  logic              pick_any;
  logic [COL_W-1:0]  pick_idx;
  logic [PERM_W-1:0] step_val;
  logic              hit_max;
  logic              hit_min;
  logic [NUM_SYN-1:0] syn_in;

  // Fixed wiring of each synapse to its input bit (R4)
  for (genvar g = 0; g < NUM_SYN; g++) begin : g_src
    localparam int unsigned SRC = syn_src(g / SYN_PER_COL, g % SYN_PER_COL,
                                          COL_SKEW, SYN_STRIDE, NUM_INPUTS);
    assign syn_in[g] = inp_q[SRC];
  end

  hpe_winner_pick #(
    .N     (NUM_COLS),
    .IDX_W (COL_W)
  ) u_pick (
    .pending_i (pend_q),
    .any_o     (pick_any),
    .idx_o     (pick_idx)
  );

  // Sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      win_q    <= '0;
      pend_q   <= '0;
      inp_q    <= '0;
      col_q    <= '0;
      syn_q    <= '0;
      addr_q   <= '0;
      rd_en_q  <= 1'b0;
      raddr_q  <= '0;
      rcol_q   <= '0;
      rinbit_q <= 1'b0;
    end else begin
      rd_en_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            win_q   <= winners_i;
            pend_q  <= winners_i;
            inp_q   <= inputs_i;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (pick_any) begin
            col_q   <= pick_idx;
            syn_q   <= '0;
            addr_q  <= ADDR_W'(pick_idx) * ADDR_W'(SYN_PER_COL);
            state_q <= ST_RUN;
          end else begin
            state_q <= ST_FLUSH;
          end
        end
        ST_RUN: begin
          rd_en_q  <= 1'b1;
          raddr_q  <= addr_q;
          rcol_q   <= col_q;
          rinbit_q <= syn_in[addr_q];
          addr_q   <= addr_q + 1'b1;
          syn_q    <= syn_q + 1'b1;
          if (syn_q == SYN_LAST) begin
            pend_q[col_q] <= 1'b0;
            state_q       <= ST_SCAN;
          end
        end
        ST_FLUSH: begin
          if (!d_vld_q && !we_q) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Data stage: read data is present
  always_ff @(posedge clk) begin
    if (rst) begin
      d_vld_q   <= 1'b0;
      d_addr_q  <= '0;
      d_inbit_q <= 1'b0;
    end else begin
      d_vld_q   <= rd_en_q;
      d_addr_q  <= raddr_q;
      d_inbit_q <= rinbit_q;
    end
  end

  hpe_perm_step #(
    .PERM_MAX  (PERM_MAX),
    .PERM_STEP (PERM_STEP),
    .W         (PERM_W)
  ) u_step (
    .perm_i    (mem_rdata_i),
    .active_i  (d_inbit_q),
    .perm_o    (step_val),
    .hit_max_o (hit_max),
    .hit_min_o (hit_min)
  );

  // Write stage
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q    <= d_vld_q;
      waddr_q <= d_addr_q;
      wdata_q <= step_val;
    end
  end

  hpe_conn_bank #(
    .N  (NUM_SYN),
    .AW (ADDR_W)
  ) u_conn (
    .clk    (clk),
    .rst    (rst),
    .upd_i  (d_vld_q),
    .addr_i (d_addr_q),
    .set_i  (hit_max),
    .clr_i  (hit_min),
    .conn_o (conn_o)
  );

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_rd_en_o = rd_en_q;
  assign mem_raddr_o = raddr_q;
  assign mem_we_o    = we_q;
  assign mem_waddr_o = waddr_q;
  assign mem_wdata_o = wdata_q;

  // R5
  wdata_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_wdata_o <= PERM_W'(PERM_MAX)))
    else $error("written permanence above full scale");

  // R8
  conn_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && mem_wdata_o == PERM_W'(PERM_MAX)) |-> conn_o[mem_waddr_o])
    else $error("full-scale write left synapse disconnected");

  // R8
  conn_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && mem_wdata_o == '0) |-> !conn_o[mem_waddr_o])
    else $error("zero write left synapse connected");

  // R3
  rd_winner_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_q |-> win_q[rcol_q])
    else $error("read issued for a non-winning column");

  // R3
  pick_pending_chk: assert property (@(posedge clk) disable iff (rst)
    pick_any |-> pend_q[pick_idx])
    else $error("picked column is not pending");

  // R10
  we_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o || mem_rd_en_o) |-> busy_o)
    else $error("memory access while idle");

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> ($stable(win_q) && $stable(inp_q)))
    else $error("start accepted while busy");

endmodule

// File: tb/hebb_perm_engine_tb.sv
module hebb_perm_engine_tb;

  localparam int NC   = 8;
  localparam int SP   = 6;
  localparam int NI   = 40;
  localparam int PM   = 10;
  localparam int PS   = 3;
  localparam int CSK  = 5;
  localparam int SST  = 7;
  localparam int NSYN = NC * SP;
  localparam int PW   = $clog2(PM + 1);
  localparam int AW   = $clog2(NSYN);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NC-1:0] win_in = '0;
  logic [NI-1:0] inp_in = '0;
  logic busy, rd_en, we;
  logic [AW-1:0] raddr, waddr;
  logic [PW-1:0] rdata, wdata;
  logic [NSYN-1:0] conn;

  always #5 clk = ~clk;

  hebb_perm_engine #(
    .NUM_COLS(NC), .SYN_PER_COL(SP), .NUM_INPUTS(NI),
    .PERM_MAX(PM), .PERM_STEP(PS), .COL_SKEW(CSK), .SYN_STRIDE(SST)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .winners_i(win_in), .inputs_i(inp_in),
    .busy_o(busy), .mem_rd_en_o(rd_en), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
    .mem_we_o(we), .mem_waddr_o(waddr), .mem_wdata_o(wdata), .conn_o(conn)
  );

  // Permanence memory model with a bench-side load port
  logic [PW-1:0] mem [NSYN];
  logic ld_en = 1'b0;
  int   ld_addr = 0;
  logic [PW-1:0] ld_data = '0;
  always @(posedge clk) begin
    if (rd_en) rdata <= mem[raddr];
    if (we) mem[waddr] <= wdata;
    else if (ld_en) mem[ld_addr] <= ld_data;
  end

  // Write monitor
  logic mon_clr = 1'b0;
  int wr_cnt [NSYN];
  int last_wa, order_err, idle_acc;
  always @(posedge clk) begin
    if (mon_clr) begin
      for (int i = 0; i < NSYN; i++) wr_cnt[i] = 0;
      last_wa = -1; order_err = 0; idle_acc = 0;
    end else begin
      if ((we || rd_en) && !busy) idle_acc++;
      if (we) begin
        wr_cnt[waddr]++;
        if (int'(waddr) <= last_wa) order_err++;
        last_wa = int'(waddr);
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  int exp_perm [NSYN];
  logic [NSYN-1:0] exp_conn = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic load(input int a, input int v);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = PW'(v);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // One pass: model, drive, wait, compare
  task automatic run_pass(input logic [NC-1:0] w, input logic [NI-1:0] x,
                          input string tag, input bit interfere);
    int cnt;
    for (int a = 0; a < NSYN; a++) exp_perm[a] = int'(mem[a]);
    for (int c = 0; c < NC; c++) begin
      if (w[c]) begin
        for (int s = 0; s < SP; s++) begin
          int a, p, n;
          a = c * SP + s;
          p = int'(mem[a]);
          if (p > PM) p = PM;
          if (x[(c * CSK + s * SST) % NI]) n = (p + PS > PM) ? PM : p + PS;
          else n = (p < PS) ? 0 : p - PS;
          exp_perm[a] = n;
          if (n == PM) exp_conn[a] = 1'b1;
          else if (n == 0) exp_conn[a] = 1'b0;
        end
      end
    end
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
    start = 1'b1; win_in = w; inp_in = x;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    if (interfere) begin
      @(negedge clk);
      start = 1'b1; win_in = ~w; inp_in = ~x;
      @(negedge clk);
      start = 1'b0;
    end
    cnt = 0;
    while (busy && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt < 2000, "R10", "busy falls", cnt, 0);
    for (int a = 0; a < NSYN; a++) begin
      int ew;
      chk(int'(mem[a]) == exp_perm[a], tag, $sformatf("perm[%0d]", a),
          mem[a], exp_perm[a]);
      ew = w[a / SP] ? 1 : 0;
      chk(wr_cnt[a] == ew, "R9", $sformatf("writes[%0d]", a), wr_cnt[a], ew);
    end
    chk(conn == exp_conn, "R8", "connected vector", conn, exp_conn);
    chk(order_err == 0, "R3", "ascending write order", order_err, 0);
    chk(idle_acc == 0, "R10", "access while idle", idle_acc, 0);
  endtask

  task automatic test_reset();
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(rd_en == 1'b0 && we == 1'b0, "R1", "mem enables", {rd_en, we}, 0);
    chk(conn == '0, "R1", "conn", conn, 0);
  endtask

  task automatic test_single();
    // column 2 with a mixed input pattern exercises the input wiring
    run_pass(8'b0000_0100, 40'h55_3C_A9_0F_C3, "R4", 1'b0);
  endtask

  task automatic test_clamp();
    // column 1 synapses sample bits 5,12,19,26,33,0
    load(6, 9); load(7, 10); load(8, 15); load(9, 1); load(10, 2); load(11, 0);
    run_pass(8'b0000_0010, (40'd1 << 5) | (40'd1 << 12) | (40'd1 << 19), "R5", 1'b0);
    chk(mem[8] == PW'(PM), "R7", "over-range clamp", mem[8], PM);
    chk(mem[10] == '0, "R6", "floor clamp", mem[10], 0);
  endtask

  task automatic test_hysteresis();
    // synapse 6 falls 10 -> 7 -> 4 -> 1 -> 0, then rises 0 -> 3
    for (int k = 0; k < 3; k++) begin
      run_pass(8'b0000_0010, '0, "R6", 1'b0);
      chk(conn[6] == 1'b1, "R8", "connected kept between endpoints", conn[6], 1);
    end
    run_pass(8'b0000_0010, '0, "R6", 1'b0);
    chk(conn[6] == 1'b0, "R8", "disconnected at zero", conn[6], 0);
    run_pass(8'b0000_0010, '1, "R5", 1'b0);
    chk(conn[6] == 1'b0, "R8", "disconnected kept rising", conn[6], 0);
  endtask

  task automatic test_no_winner();
    run_pass('0, '1, "R3", 1'b0);
  endtask

  task automatic test_start_busy();
    // second start with complementary winners must have no effect
    run_pass(8'b0000_0001, '1, "R2", 1'b1);
    chk(wr_cnt[NSYN-1] == 0, "R2", "column 7 untouched", wr_cnt[NSYN-1], 0);
  endtask

  task automatic test_all();
    run_pass('1, 40'hA5_C3_96_F0_1B, "R9", 1'b0);
    run_pass(8'b1010_0101, 40'h0F_F0_33_CC_5A, "R3", 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    for (int a = 0; a < NSYN; a++) load(a, (a * 7 + 3) % 9 + 1);
    test_single();
    test_clamp();
    test_hysteresis();
    test_no_winner();
    test_start_busy();
    test_all();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule